// File: doc/BRIEF.md
# Programmable-Ratio Fifth-Order CIC Decimator

This block is the first rate-reduction stage behind a single-bit sigma-delta modulator. Each clock carries one modulator bit. The bit is mapped to +1 or -1 and fed into a chain of five wrap-around integrators that run at the input rate. Once every R input samples, the last integrator is sampled into a chain of five differentiators that run at the output rate. Each differentiator has a delay of one output sample. The result comes out with a single-cycle valid strobe.

The ratio R is chosen from seven powers of two, 32 to 2048. The choice sets the output sample rate and the filter's pass and stop edges. The ratio is latched only while the synchronous reset is held, so a change takes effect through a reset. The block provides two outputs. The first is the full-precision differentiator result. The second is a word normalised so that DC gain is unity at every ratio: the result is multiplied by 2^(5·(11−log2 R)) and its top bits are kept. After a reset the first five decimation instants are not flagged valid, because the differentiator delay lines are still filling.

Top module: `cic_decim`

## Requirements
- R1: An input bit of 1 adds +1 to the first integrator and a bit of 0 adds −1. All integrator and differentiator arithmetic wraps in two's complement at 57 bits.
- R2: `ratio_sel` codes 0 to 6 select R = 32·2^code. Code 7 selects R = 2048.
- R3: `out_valid` is a single-cycle pulse. Once running, consecutive pulses are exactly R clock cycles apart.
- R4: After reset release, the first five decimation instants produce no pulse. The first pulse appears after clock edge 6R, counting the first edge with reset low as edge 1.
- R5: `ratio_sel` is sampled only on clock edges where `rst` is high. Changing it while running leaves the pulse spacing unchanged.
- R6: With a constant input of 1, the settled `out_full` equals +R^5. With a constant input of 0 it equals −R^5. With alternating bits it equals 0.
- R7: `out_trunc` equals floor(`out_full`·2^(5·(11−log2 R)) / 2^33), kept to 24 bits. For a constant input of 1 it is 2^22 at every ratio.
- R8: The output stays correct when the integrators wrap. An all-ones run at R = 2048 still settles to `out_full` = 2^55.
- R9: While and just after the synchronous reset, `out_valid`, `out_full` and `out_trunc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock; one input bit per cycle |
| rst | input | 1 | Synchronous reset, active high; also latches `ratio_sel` |
| ratio_sel | input | 3 | Ratio code, R = 32·2^code, with 7 treated as 2048 |
| din | input | 1 | Modulator bit (1 → +1, 0 → −1) |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| out_full | output | 57 | Full-precision signed differentiator result |
| out_trunc | output | 24 | Signed output normalised to unity DC gain |

## Verification
The bench builds the block with its defaults: order five, ratio codes spanning 32 to 2048, and a 24-bit normalised output. These defaults cover the out-of-range ratio code. At the largest ratio, an all-ones run of several thousand samples drives the integrators well past their 57-bit range, so the wrap-around argument is tested directly. A behavioural model built from integer arrays predicts every cycle's strobe and both output words. DC, alternating and random bit patterns are run at several ratios, and one run changes the ratio code while the block is active.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;

    // Ratio code to log2 of the decimation ratio; codes past the last
    // supported ratio saturate at the largest one.
    function automatic int unsigned code_to_log2(
        input int unsigned code,
        input int unsigned log2_min,
        input int unsigned n_ratios
    );
        if (code >= n_ratios) begin
            return log2_min + n_ratios - 1;
        end
        return log2_min + code;
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
    parameter int ORDER    = 5,
    parameter int LOG2_MIN = 5,
    parameter int N_RATIOS = 7,
    parameter int SEL_W    = 3,
    parameter int LOG_W    = 4,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             tick,
    output logic             primed,
    output logic [LOG_W-1:0] ratio_log2
);
    import cic_decim_pkg::*;

    localparam int LOG2_MAX = LOG2_MIN + N_RATIOS - 1;
    localparam int PRIME_W  = $clog2(ORDER + 1);

    typedef struct packed {
        logic [LOG_W-1:0]   lg;
        logic [CNT_W-1:0]   cnt;
        logic [PRIME_W-1:0] prime;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = {CNT_W{1'b1}} >> (LOG2_MAX - int'(st_q.lg));
        tick     = (st_q.cnt == last_cnt);
        primed   = (st_q.prime == PRIME_W'(ORDER));
        st_d     = st_q;
        if (rst) begin
            st_d.lg    = LOG_W'(code_to_log2(ratio_sel, LOG2_MIN, N_RATIOS));
            st_d.cnt   = '0;
            st_d.prime = '0;
        end else begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
            if (tick && !primed) begin
                st_d.prime = st_q.prime + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ratio_log2 = st_q.lg;

    // R5: the latched ratio moves only through reset
    a_r5_ratio_locked: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(st_q.lg));

    // R4: priming count never exceeds the filter order
    a_r4_prime_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.prime <= PRIME_W'(ORDER));

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int ORDER = 5,
    parameter int ACC_W = 57
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [ACC_W-1:0] acc_last
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;
    logic [ACC_W-1:0] step;
    logic [ORDER-1:0][ACC_W-1:0] nxt;

    // +1 for a one, all ones (-1) for a zero
    assign step = {{(ACC_W-1){~din}}, 1'b1};

    assign nxt[0] = st_q.acc[0] + step;
    for (genvar k = 1; k < ORDER; k++) begin : g_stage
        assign nxt[k] = st_q.acc[k] + st_q.acc[k-1];
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc_last = st_q.acc[ORDER-1];

    // R1: first integrator moves by exactly one unit each cycle
    a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((st_q.acc[0] - $past(st_q.acc[0])) ==
                         ($past(din) ? ACC_W'(1) : {ACC_W{1'b1}})));

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int ORDER = 5,
    parameter int ACC_W = 57
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [ACC_W-1:0] samp,
    output logic [ACC_W-1:0] comb_out
);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]            res;
    } comb_t;

    comb_t st_d, st_q;
    logic [ORDER:0][ACC_W-1:0] stage;

    assign stage[0] = samp;
    for (genvar k = 0; k < ORDER; k++) begin : g_diff
        assign stage[k+1] = stage[k] - st_q.dly[k];
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (tick) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.dly[k] = stage[k];
            end
            st_d.res = stage[ORDER];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign comb_out = st_q.res;

    // R3: the output word changes only at a decimation instant
    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(rst)) |-> $stable(st_q.res));

endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
    parameter int ORDER    = 5,
    parameter int LOG2_MIN = 5,
    parameter int N_RATIOS = 7,
    parameter int OUT_W    = 24,
    parameter int LOG2_MAX = LOG2_MIN + N_RATIOS - 1,
    parameter int ACC_W    = 2 + ORDER * LOG2_MAX,
    parameter int SEL_W    = $clog2(N_RATIOS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SEL_W-1:0]        ratio_sel,
    input  logic                    din,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_full,
    output logic signed [OUT_W-1:0] out_trunc
);

    localparam int LOG_W = $clog2(LOG2_MAX + 1);

    typedef struct packed {
        logic valid;
    } out_t;

    out_t st_d, st_q;

    logic             tick;
    logic             primed;
    logic [LOG_W-1:0] ratio_log2;
    logic [ACC_W-1:0] integ_last;
    logic [ACC_W-1:0] comb_res;
    logic signed [ACC_W-1:0] norm;
    logic signed [ACC_W-1:0] bound;

    cic_rate_ctrl #(
        .ORDER(ORDER), .LOG2_MIN(LOG2_MIN), .N_RATIOS(N_RATIOS),
        .SEL_W(SEL_W), .LOG_W(LOG_W), .CNT_W(LOG2_MAX)
    ) u_ctrl (
        .clk(clk), .rst(rst), .ratio_sel(ratio_sel),
        .tick(tick), .primed(primed), .ratio_log2(ratio_log2)
    );

    cic_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst(rst), .din(din), .acc_last(integ_last)
    );

    cic_comb_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst(rst), .tick(tick), .samp(integ_last), .comb_out(comb_res)
    );

    always_comb begin
        st_d.valid = !rst && tick && primed;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        norm  = $signed(comb_res) <<< (ORDER * (LOG2_MAX - int'(ratio_log2)));
        bound = $signed(ACC_W'(1) << (ORDER * int'(ratio_log2)));
    end

    assign out_valid = st_q.valid;
    assign out_full  = $signed(comb_res);
    assign out_trunc = OUT_W'(norm >>> (ACC_W - OUT_W));

    // R3: strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: no strobe before the delay lines are full
    a_r4_primed_only: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> primed);

    // R9: nothing valid on the cycle after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_full == '0));

    // R6: a flagged sample never exceeds the filter's DC gain
    a_r6_gain_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_full <= bound && out_full >= -bound));

endmodule

// File: tb/tb_cic_decim.sv
`timescale 1ns/1ps
module tb_cic_decim;

    localparam int AW = 57;
    localparam int OW = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic din = 1'b0;
    logic out_valid;
    logic signed [AW-1:0] out_full;
    logic signed [OW-1:0] out_trunc;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cic_decim dut (
        .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .din(din),
        .out_valid(out_valid), .out_full(out_full), .out_trunc(out_trunc)
    );

    // ---------------- behavioural reference ----------------
    int m_log = 5;
    int m_cnt = 0;
    int m_prime = 0;
    bit m_started = 0;
    logic signed [AW-1:0] m_int [5];
    logic signed [AW-1:0] m_dly [5];
    logic signed [AW-1:0] e_full = '0;
    bit e_valid = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_log = (ratio_sel >= 3'd6) ? 11 : 5 + int'(ratio_sel);
            m_cnt = 0; m_prime = 0; e_valid = 0; e_full = '0;
            for (int k = 0; k < 5; k++) begin m_int[k] = '0; m_dly[k] = '0; end
        end else begin
            logic signed [AW-1:0] nx [5];
            logic signed [AW-1:0] c, t;
            nx[0] = m_int[0] + (din ? AW'(1) : -AW'(1));
            for (int k = 1; k < 5; k++) nx[k] = m_int[k] + m_int[k-1];
            e_valid = 0;
            if (m_cnt == (1 << m_log) - 1) begin
                c = m_int[4];
                for (int k = 0; k < 5; k++) begin
                    t = c - m_dly[k]; m_dly[k] = c; c = t;
                end
                e_full = c;
                e_valid = (m_prime == 5);
                if (m_prime < 5) m_prime++;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            for (int k = 0; k < 5; k++) m_int[k] = nx[k];
        end
        m_started = 1;
    end

    function automatic logic signed [OW-1:0] trunc_of(input logic signed [AW-1:0] v, input int lg);
        logic signed [AW-1:0] s;
        s = (v <<< (5 * (11 - lg))) >>> (AW - OW);
        return s[OW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (m_started) begin
            check(out_valid == e_valid, "R3 strobe vs model", out_valid, e_valid);
            check(out_full == e_full, "R6 out_full vs model", out_full, e_full);
            check(out_trunc == trunc_of(e_full, m_log), "R7 out_trunc vs model",
                  out_trunc, trunc_of(e_full, m_log));
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input logic [2:0] code, input bit level);
        @(negedge clk);
        rst = 1'b1; ratio_sel = code; din = level;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && out_full == '0 && out_trunc == '0,
              "R9 reset clears outputs", out_full, 0);
        rst = 1'b0;
    endtask

    // mode 0 zeros, 1 ones, 2 alternating, 3 random
    task automatic run(input int mode, input int nval, input int ratio,
                       input bit poke, input string req_gap);
        int k = 0;
        int seen = 0;
        int last = 0;
        bit alt = 0;
        while (seen < nval) begin
            case (mode)
                0: din = 1'b0;
                1: din = 1'b1;
                2: begin din = alt; alt = ~alt; end
                default: din = 1'($urandom_range(0, 1));
            endcase
            if (poke && k == 7 * ratio) ratio_sel = 3'd6;
            @(negedge clk);
            k++;
            if (out_valid) begin
                seen++;
                if (seen == 1) check(k == 6 * ratio, "R4 first strobe edge", k, 6 * ratio);
                else check(k - last == ratio, req_gap, k - last, ratio);
                last = k;
            end else if (seen == 0 && k > 6 * ratio) begin
                check(0, "R4 strobe missing", k, 6 * ratio);
                seen = nval;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);

        // R1 R6 R7: all ones, R = 32
        do_reset(3'd0, 1'b1);
        run(1, 10, 32, 0, "R3 gap 32");
        check(out_full == 64'sd33554432, "R6 ones full R=32", out_full, 33554432);
        check(out_trunc == 24'sd4194304, "R7 ones trunc R=32", out_trunc, 4194304);

        // R1 R6: all zeros
        do_reset(3'd0, 1'b0);
        run(0, 10, 32, 0, "R3 gap 32 zeros");
        check(out_full == -64'sd33554432, "R6 zeros full R=32", out_full, -33554432);
        check(out_trunc == -24'sd4194304, "R7 zeros trunc R=32", out_trunc, -4194304);

        // R2 R6: alternating at R = 64
        do_reset(3'd1, 1'b0);
        run(2, 10, 64, 0, "R2 gap 64");
        check(out_full == 0, "R6 alternating full R=64", out_full, 0);

        // R5: code changed while running, R = 128 must persist
        do_reset(3'd2, 1'b0);
        run(3, 20, 128, 1, "R5 gap after code change");

        // R2: code 3 gives 256, random input
        do_reset(3'd3, 1'b0);
        run(3, 8, 256, 0, "R2 gap 256");

        // R2 R8 R7: code 7 saturates to 2048, integrators wrap
        do_reset(3'd7, 1'b1);
        run(1, 9, 2048, 0, "R2 gap 2048 code 7");
        check(out_full == (64'sd1 <<< 55), "R8 ones full R=2048", out_full, 64'sd1 <<< 55);
        check(out_trunc == 24'sd4194304, "R7 ones trunc R=2048", out_trunc, 4194304);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule